// File: doc/BRIEF.md
# Serial Display-Memory and Command Port

This block is the host-facing side of a small segment-display controller. A host drives an active-low select, an active-low write strobe, an active-low read strobe and a data line. The block watches these pins with the system clock and turns each frame into work. A frame opens with a three-bit mode code. The frame can then write nibbles into a 32-word by 4-bit display memory, read nibbles back, interleave reads and writes on the same word, or carry a run of 9-bit configuration commands. Each command is decoded into a one-cycle strobe for the timer, tone and display blocks.

The pad is modelled as separate input and output bits plus an output enable. The memory is outside the block. It offers a combinational read port addressed by `mem_raddr` and a registered write port, and it must not change except through this block's write port. All four host pins pass through the same synchronizer, so data keeps its alignment with the strobe edges. A strobe level must therefore hold for more than the synchronizer depth plus one cycle.

Top module: `disp_serial_port`

## Requirements
- R1: While select (`cs_n`) is high, the block abandons any partial frame and holds `data_oe`, `mem_we` and `cmd_hit` low. Bits sent after select returns low are taken as a fresh mode code.
- R2: The first three write-strobe rising edges carry the mode code, first bit first: 110 is read, 101 is write / read-modify-write, 100 is command. Any other code makes the block ignore the rest of the frame: no memory write, no strobe, and `data_oe` stays low.
- R3: In a data mode, the next six rising edges carry the address, most significant bit first. Only the low five bits select the word; the top bit is ignored. In write mode, nibble bits follow least significant bit first. The fourth bit makes `mem_we` high for exactly one cycle with `mem_waddr` and `mem_wdata` set.
- R4: In read mode, each read-strobe falling edge puts the next bit of the current word on `data_out`, least significant bit first. After the fourth bit, the address advances.
- R5: In write mode, each completed nibble advances the address by one, so a stream fills consecutive words. Word 31 wraps to word 0.
- R6: In write mode, read-strobe falls return bits of the current word without advancing the address. A nibble written after those reads replaces that same word, and only then does the address move on (read-modify-write).
- R7: `data_oe` rises on a read-strobe fall during the data phase. It drops on a write-strobe rise in write mode and when select goes high. It is never high in the mode-code, address or command phases.
- R8: In command mode, every nine rising edges form one command, first bit C8 and last bit C0. C0 is ignored. Further commands follow with no new mode code until select goes high. `cmd_hit` pulses for one cycle after the ninth bit.
- R9: With C8..C1 written as an 8-bit code, the one-hot `cmd_hit` index is set as follows:
  - 0 for 0x00 (system off), 1 for 0x01 (system on), 2 for 0x02 (display off), 3 for 0x03 (display on).
  - 4 for 0x04 (timer off), 5 for 0x05 (watchdog off), 6 for 0x06 (timer on), 7 for 0x07 (watchdog on).
  - 8 for 0x08 (tone off), 9 for 0x0D (timer clear), 10 for 0000111x (watchdog clear).
  - 11 for 0010xxxx (bias/commons), 12 for 010xxxxx (tone high), 13 for 0110xxxx (tone low).
  - 14 for 100x0xxx (IRQ off), 15 for 100x1xxx (IRQ on), 16 for 101x0xxx (rate select).
- R10: At most one `cmd_hit` bit is set at a time. No bit is set for a code outside R9. `cmd_bits` carries C8..C1 (C8 in bit 7) during the pulse.
- R11: If a read-strobe fall and a write-strobe rise land in the same cycle in write mode, the read bit comes from the word as it was before that cycle's write. The written bit is still captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host select, active low |
| wr_n | input | 1 | Host write strobe, sampled on its rising edge |
| rd_n | input | 1 | Host read strobe, data driven after its falling edge |
| data_in | input | 1 | Data line as seen at the pad input |
| data_out | output | 1 | Data bit to drive onto the pad |
| data_oe | output | 1 | Pad output enable |
| mem_raddr | output | 5 | Display-memory read address |
| mem_rdata | input | 4 | Display-memory read data (combinational) |
| mem_we | output | 1 | Display-memory write enable, one cycle |
| mem_waddr | output | 5 | Display-memory write address |
| mem_wdata | output | 4 | Display-memory write nibble |
| cmd_hit | output | 17 | One-hot decoded command strobe |
| cmd_bits | output | 8 | Command code C8..C1 that came with the strobe |

## Verification
In write mode a read-strobe fall and a write-strobe rise can be detected in the same clock cycle. One step is then both the read half and the write half of read-modify-write. The bench provokes this by releasing the write strobe and lowering the read strobe at the same instant for each of the four bits of a nibble. It expects every returned bit to match the word's old content and the scoreboard to see the new nibble written to the same address. A later read-mode frame confirms that the new value is in place and that the address advanced only once.

// File: rtl/serif_pkg.sv
package serif_pkg;

    localparam int ID_BITS = 3;
    localparam logic [ID_BITS-1:0] ID_READ  = 3'b110;
    localparam logic [ID_BITS-1:0] ID_WRITE = 3'b101;
    localparam logic [ID_BITS-1:0] ID_CMD   = 3'b100;

    localparam int CMD_BITS = 9;
    localparam int NUM_CMD  = 17;

    localparam int CI_SYS_OFF  = 0;
    localparam int CI_SYS_ON   = 1;
    localparam int CI_DISP_OFF = 2;
    localparam int CI_DISP_ON  = 3;
    localparam int CI_TMR_OFF  = 4;
    localparam int CI_WDG_OFF  = 5;
    localparam int CI_TMR_ON   = 6;
    localparam int CI_WDG_ON   = 7;
    localparam int CI_TONE_OFF = 8;
    localparam int CI_TMR_CLR  = 9;
    localparam int CI_WDG_CLR  = 10;
    localparam int CI_BIAS     = 11;
    localparam int CI_TONE_HI  = 12;
    localparam int CI_TONE_LO  = 13;
    localparam int CI_IRQ_OFF  = 14;
    localparam int CI_IRQ_ON   = 15;
    localparam int CI_RATE     = 16;

    typedef enum logic [2:0] {
        PH_ID,
        PH_ADDR,
        PH_DATA,
        PH_CMD,
        PH_SKIP
    } phase_e;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins,
    output logic [WIDTH-1:0] level
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pins[i]};
            end
        end

        assign level[i] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
    import serif_pkg::*;
(
    input  logic [7:0]         code,
    output logic [NUM_CMD-1:0] hit
);
    always_comb begin
        hit = '0;
        casez (code)
            8'b0000_0000: hit[CI_SYS_OFF]  = 1'b1;
            8'b0000_0001: hit[CI_SYS_ON]   = 1'b1;
            8'b0000_0010: hit[CI_DISP_OFF] = 1'b1;
            8'b0000_0011: hit[CI_DISP_ON]  = 1'b1;
            8'b0000_0100: hit[CI_TMR_OFF]  = 1'b1;
            8'b0000_0101: hit[CI_WDG_OFF]  = 1'b1;
            8'b0000_0110: hit[CI_TMR_ON]   = 1'b1;
            8'b0000_0111: hit[CI_WDG_ON]   = 1'b1;
            8'b0000_1000: hit[CI_TONE_OFF] = 1'b1;
            8'b0000_1101: hit[CI_TMR_CLR]  = 1'b1;
            8'b0000_111?: hit[CI_WDG_CLR]  = 1'b1;
            8'b0010_????: hit[CI_BIAS]     = 1'b1;
            8'b010?_????: hit[CI_TONE_HI]  = 1'b1;
            8'b0110_????: hit[CI_TONE_LO]  = 1'b1;
            8'b100?_0???: hit[CI_IRQ_OFF]  = 1'b1;
            8'b100?_1???: hit[CI_IRQ_ON]   = 1'b1;
            8'b101?_0???: hit[CI_RATE]     = 1'b1;
            default:      hit = '0;
        endcase
    end
endmodule

// File: rtl/disp_serial_port.sv
module disp_serial_port
    import serif_pkg::*;
#(
    parameter int ADDR_BITS   = 6,
    parameter int MEM_AW      = 5,
    parameter int NIB_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               wr_n,
    input  logic               rd_n,
    input  logic               data_in,
    output logic               data_out,
    output logic               data_oe,
    output logic [MEM_AW-1:0]  mem_raddr,
    input  logic [NIB_W-1:0]   mem_rdata,
    output logic               mem_we,
    output logic [MEM_AW-1:0]  mem_waddr,
    output logic [NIB_W-1:0]   mem_wdata,
    output logic [NUM_CMD-1:0] cmd_hit,
    output logic [7:0]         cmd_bits
);
    localparam int BIT_W = $clog2(NIB_W);
    localparam int CNT_W = $clog2(CMD_BITS);
    localparam int SH_W  = CMD_BITS - 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(NIB_W - 1);

    typedef struct packed {
        phase_e             phase;
        logic               is_read;
        logic [CNT_W-1:0]   cnt;
        logic [SH_W-1:0]    sh;
        logic [MEM_AW-1:0]  addr;
        logic [BIT_W-1:0]   rbit;
        logic [BIT_W-1:0]   wbit;
        logic [NIB_W-1:0]   wacc;
        logic               dout;
        logic               oe;
        logic               we;
        logic [MEM_AW-1:0]  waddr;
        logic [NIB_W-1:0]   wdata;
        logic [NUM_CMD-1:0] hit;
        logic [7:0]         bits;
        logic               wr_prev;
        logic               rd_prev;
    } st_t;

    st_t q, d;

    logic [3:0] lvl;
    logic cs_lvl, wr_lvl, rd_lvl, din;
    logic wr_rise, rd_fall, wr_done;
    logic [NIB_W-1:0] nib;
    logic [NUM_CMD-1:0] dec_hit;

    pin_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pins ({data_in, rd_n, wr_n, cs_n}),
        .level(lvl)
    );

    assign cs_lvl = lvl[0];
    assign wr_lvl = lvl[1];
    assign rd_lvl = lvl[2];
    assign din    = lvl[3];

    cmd_decode u_dec (
        .code(q.sh[7:0]),
        .hit (dec_hit)
    );

    assign wr_rise = wr_lvl & ~q.wr_prev;
    assign rd_fall = ~rd_lvl & q.rd_prev;
    assign wr_done = wr_rise && (q.phase == PH_DATA) && !q.is_read && (q.wbit == LAST_BIT);

    always_comb begin
        d         = q;
        d.we      = 1'b0;
        d.hit     = '0;
        d.wr_prev = wr_lvl;
        d.rd_prev = rd_lvl;
        nib       = q.wacc;
        nib[q.wbit] = din;

        if (cs_lvl) begin
            d.phase = PH_ID;
            d.cnt   = '0;
            d.sh    = '0;
            d.rbit  = '0;
            d.wbit  = '0;
            d.oe    = 1'b0;
            d.dout  = 1'b0;
        end else begin
            if (wr_rise) begin
                unique case (q.phase)
                    PH_ID: begin
                        d.sh = {q.sh[SH_W-2:0], din};
                        if (q.cnt == CNT_W'(ID_BITS - 1)) begin
                            d.cnt = '0;
                            case ({q.sh[ID_BITS-2:0], din})
                                ID_READ:  begin d.phase = PH_ADDR; d.is_read = 1'b1; end
                                ID_WRITE: begin d.phase = PH_ADDR; d.is_read = 1'b0; end
                                ID_CMD:   d.phase = PH_CMD;
                                default:  d.phase = PH_SKIP;
                            endcase
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                    PH_ADDR: begin
                        d.sh = {q.sh[SH_W-2:0], din};
                        if (q.cnt == CNT_W'(ADDR_BITS - 1)) begin
                            d.cnt   = '0;
                            d.addr  = {q.sh[MEM_AW-2:0], din};
                            d.phase = PH_DATA;
                            d.rbit  = '0;
                            d.wbit  = '0;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        if (!q.is_read) begin
                            d.oe   = 1'b0;
                            d.wacc = nib;
                            if (wr_done) begin
                                d.we    = 1'b1;
                                d.waddr = q.addr;
                                d.wdata = nib;
                                d.addr  = q.addr + 1'b1;
                                d.wbit  = '0;
                                d.rbit  = '0;
                            end else begin
                                d.wbit = q.wbit + 1'b1;
                            end
                        end
                    end
                    PH_CMD: begin
                        d.sh = {q.sh[SH_W-2:0], din};
                        if (q.cnt == CNT_W'(CMD_BITS - 1)) begin
                            d.cnt  = '0;
                            d.hit  = dec_hit;
                            d.bits = q.sh[7:0];
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end

            if (rd_fall && q.phase == PH_DATA) begin
                d.dout = mem_rdata[q.rbit];
                d.oe   = 1'b1;
                if (q.is_read && q.rbit == LAST_BIT) begin
                    d.addr = q.addr + 1'b1;
                    d.rbit = '0;
                end else if (!wr_done) begin
                    d.rbit = q.rbit + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.wr_prev <= 1'b1;
            q.rd_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign data_out  = q.dout;
    assign data_oe   = q.oe;
    assign mem_raddr = q.addr;
    assign mem_we    = q.we;
    assign mem_waddr = q.waddr;
    assign mem_wdata = q.wdata;
    assign cmd_hit   = q.hit;
    assign cmd_bits  = q.bits;

endmodule

// File: rtl/disp_serial_port_chk.sv
module disp_serial_port_chk
    import serif_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cs_lvl,
    input logic               data_oe,
    input logic               mem_we,
    input logic [NUM_CMD-1:0] cmd_hit
);
    // R1
    sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |=> (!data_oe && !mem_we && cmd_hit == '0));

    // R10
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_hit));

    // R8
    hit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit != '0) |=> (cmd_hit == '0));

    // R3
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R7
    cmd_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit != '0) |-> !data_oe);
endmodule

bind disp_serial_port disp_serial_port_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_lvl (cs_lvl),
    .data_oe(data_oe),
    .mem_we (mem_we),
    .cmd_hit(cmd_hit)
);

// File: tb/tb_disp_serial_port.sv
module tb_disp_serial_port;
    import serif_pkg::*;

    localparam int HALF = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, cs_n, wr_n, rd_n, data_in;
    logic data_out, data_oe, mem_we;
    logic [4:0] mem_raddr, mem_waddr;
    logic [3:0] mem_rdata, mem_wdata;
    logic [NUM_CMD-1:0] cmd_hit;
    logic [7:0] cmd_bits;

    disp_serial_port dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .cmd_hit(cmd_hit), .cmd_bits(cmd_bits)
    );

    typedef struct packed {
        logic       is_cmd;
        logic [4:0] addr;
        logic [3:0] nib;
        logic [4:0] idx;
        logic [7:0] bits;
    } item_t;

    item_t exp_q[$];
    string tag_q[$];
    int checks = 0;
    int errors = 0;
    int cur = 0;
    logic [3:0] mem   [32];
    logic [3:0] model [32];

    function automatic logic [3:0] seed(int i);
        return 4'((i * 7 + 3) % 16);
    endfunction

    initial begin
        for (int i = 0; i < 32; i++) begin
            mem[i]   = seed(i);
            model[i] = seed(i);
        end
    end

    always @(posedge clk) if (mem_we) mem[mem_waddr] <= mem_wdata;
    assign mem_rdata = mem[mem_raddr];

    task automatic check(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        item_t e;
        string t;
        if (rst_n && (mem_we || cmd_hit != '0)) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2 unexpected event actual=%0h expected=0", {mem_we, cmd_hit});
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e.is_cmd) begin
                    check(cmd_hit == (NUM_CMD'(1) << e.idx) && !mem_we, t, "strobe",
                          int'(cmd_hit), int'(NUM_CMD'(1) << e.idx));
                    check(cmd_bits == e.bits, t, "cmd_bits", int'(cmd_bits), int'(e.bits));
                end else begin
                    check(mem_we && mem_waddr == e.addr && mem_wdata == e.nib, t, "write",
                          int'({mem_we, mem_waddr, mem_wdata}), int'({1'b1, e.addr, e.nib}));
                end
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_bit(logic b);
        data_in = b; wr_n = 1'b0; idle(HALF);
        wr_n = 1'b1; idle(HALF);
    endtask

    task automatic rd_bit(output logic v);
        rd_n = 1'b0; idle(HALF);
        v = data_out;
        rd_n = 1'b1; idle(HALF);
    endtask

    task automatic cs_gap();
        cs_n = 1'b1; idle(HALF);
        cs_n = 1'b0; idle(HALF);
    endtask

    task automatic send_bits(logic [8:0] v, int n);
        for (int i = n - 1; i >= 0; i--) wr_bit(v[i]);
    endtask

    task automatic start_frame(logic [2:0] id, logic [5:0] a);
        send_bits({6'b0, id}, 3);
        send_bits({3'b0, a}, 6);
        cur = int'(a[4:0]);
    endtask

    task automatic put_nib(logic [3:0] n, string tag);
        exp_q.push_back('{is_cmd: 1'b0, addr: 5'(cur), nib: n, idx: 5'd0, bits: 8'd0});
        tag_q.push_back(tag);
        for (int i = 0; i < 4; i++) wr_bit(n[i]);
        check(data_oe == 1'b0, "R7", "oe after write bit", int'(data_oe), 0);
        model[cur] = n;
        cur = (cur + 1) % 32;
    endtask

    task automatic get_nib(bit adv, string tag);
        logic v;
        logic [3:0] got;
        for (int i = 0; i < 4; i++) begin
            rd_bit(v);
            got[i] = v;
        end
        check(got == model[cur], tag, "read nibble", int'(got), int'(model[cur]));
        check(data_oe == 1'b1, "R7", "oe in read phase", int'(data_oe), 1);
        if (adv) cur = (cur + 1) % 32;
    endtask

    task automatic put_cmd(logic [7:0] code, int idx, logic c0, string tag);
        if (idx >= 0) begin
            exp_q.push_back('{is_cmd: 1'b1, addr: 5'd0, nib: 4'd0, idx: 5'(idx), bits: code});
            tag_q.push_back(tag);
        end
        send_bits({code, c0}, 9);
    endtask

    // same-cycle read fall and write rise for each bit of a nibble
    task automatic combo_nib(logic [3:0] n);
        logic [3:0] old;
        logic [3:0] got;
        old = model[cur];
        exp_q.push_back('{is_cmd: 1'b0, addr: 5'(cur), nib: n, idx: 5'd0, bits: 8'd0});
        tag_q.push_back("R11");
        for (int i = 0; i < 4; i++) begin
            data_in = n[i]; wr_n = 1'b0; idle(HALF);
            wr_n = 1'b1; rd_n = 1'b0; idle(HALF);
            got[i] = data_out;
            rd_n = 1'b1; idle(HALF);
        end
        check(got == old, "R11", "combo read bits", int'(got), int'(old));
        model[cur] = n;
        cur = (cur + 1) % 32;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic v;
        rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; data_in = 1'b0;
        idle(4);
        rst_n = 1'b1;
        idle(4);
        // R1 reset state
        check(data_oe == 0 && mem_we == 0 && cmd_hit == '0, "R1", "reset outputs",
              int'({data_oe, mem_we, cmd_hit}), 0);
        cs_n = 1'b0; idle(HALF);

        // R3 R5 streaming write from word 3
        start_frame(ID_WRITE, 6'd3);
        put_nib(4'hA, "R3");
        put_nib(4'h5, "R5");
        put_nib(4'hC, "R5");
        cs_gap();
        check(data_oe == 0, "R1", "oe after select", int'(data_oe), 0);

        // R4 streaming read 3..6
        start_frame(ID_READ, 6'd3);
        for (int k = 0; k < 4; k++) get_nib(1'b1, "R4");
        cs_n = 1'b1; idle(HALF);
        check(data_oe == 0, "R7", "oe dropped by select", int'(data_oe), 0);
        cs_n = 1'b0; idle(HALF);

        // R3 top address bit ignored, R5 wrap 31 -> 0
        start_frame(ID_WRITE, 6'b111111);
        put_nib(4'h1, "R5");
        put_nib(4'h2, "R5");
        cs_gap();
        start_frame(ID_READ, 6'b011111);
        get_nib(1'b1, "R5");
        get_nib(1'b1, "R5");
        cs_gap();

        // R6 read-modify-write on words 10 and 11
        start_frame(ID_WRITE, 6'd10);
        get_nib(1'b0, "R6");
        put_nib(4'h9, "R6");
        get_nib(1'b0, "R6");
        put_nib(4'h6, "R6");
        cs_gap();

        // R11 same-cycle read and write on word 20
        start_frame(ID_WRITE, 6'd20);
        combo_nib(4'h3);
        cs_gap();

        // R2 unknown mode code: no write, no drive
        send_bits(9'b111, 3);
        send_bits(9'b000101, 6);
        send_bits(9'hF, 4);
        rd_bit(v);
        check(data_oe == 0, "R2", "oe after unknown code", int'(data_oe), 0);
        cs_gap();

        // R1 partial mode code abandoned by select
        send_bits(9'b10, 2);
        cs_gap();
        start_frame(ID_READ, 6'd3);
        get_nib(1'b1, "R1");
        cs_gap();

        // R1 partial nibble abandoned, then new frame on word 13
        start_frame(ID_WRITE, 6'd12);
        wr_bit(1'b1);
        wr_bit(1'b1);
        cs_gap();
        start_frame(ID_WRITE, 6'd13);
        put_nib(4'h4, "R1");
        cs_gap();

        // R8 R9 R10 command stream without repeated mode code
        send_bits({6'b0, ID_CMD}, 3);
        put_cmd(8'h00, CI_SYS_OFF, 1'b1, "R9");
        put_cmd(8'h01, CI_SYS_ON, 1'b0, "R9");
        put_cmd(8'h02, CI_DISP_OFF, 1'b1, "R9");
        put_cmd(8'h03, CI_DISP_ON, 1'b0, "R9");
        put_cmd(8'h04, CI_TMR_OFF, 1'b1, "R9");
        put_cmd(8'h05, CI_WDG_OFF, 1'b0, "R9");
        put_cmd(8'h06, CI_TMR_ON, 1'b1, "R9");
        put_cmd(8'h07, CI_WDG_ON, 1'b0, "R9");
        put_cmd(8'h08, CI_TONE_OFF, 1'b1, "R9");
        put_cmd(8'h09, -1, 1'b1, "R10");
        put_cmd(8'h0D, CI_TMR_CLR, 1'b0, "R9");
        put_cmd(8'h0E, CI_WDG_CLR, 1'b1, "R9");
        put_cmd(8'h0F, CI_WDG_CLR, 1'b0, "R9");
        put_cmd(8'b0010_1011, CI_BIAS, 1'b1, "R9");
        put_cmd(8'b0101_0110, CI_TONE_HI, 1'b0, "R9");
        put_cmd(8'b0110_1010, CI_TONE_LO, 1'b1, "R9");
        put_cmd(8'b1001_0110, CI_IRQ_OFF, 1'b0, "R9");
        put_cmd(8'b1000_1000, CI_IRQ_ON, 1'b1, "R9");
        put_cmd(8'b1011_0101, CI_RATE, 1'b0, "R8");
        put_cmd(8'b1010_1000, -1, 1'b1, "R10");
        put_cmd(8'b1110_0011, -1, 1'b0, "R10");
        check(data_oe == 0, "R7", "oe in command phase", int'(data_oe), 0);
        cs_gap();

        // read back every touched word
        start_frame(ID_READ, 6'd10);
        for (int k = 0; k < 4; k++) get_nib(1'b1, "R6");
        cs_gap();
        start_frame(ID_READ, 6'd20);
        get_nib(1'b1, "R11");
        cs_gap();

        idle(20);
        check(exp_q.size() == 0, "R8", "scoreboard drained", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule